// File: doc/BRIEF.md
# Array Write-Protection Arbiter

This block decides, one request at a time, whether a write into a 256-byte nonvolatile array may go ahead. It combines two independent guards. The first is a one-shot software lock that, once armed by a dedicated bus command, fences off the lower half of the array (addresses 0 to 127) for good. The second is an external protect pin that, while asserted, fences off every address. Together they give no protection, protection of the lower half, or protection of the whole array.

The serial front end hands the block an already decoded 4-bit control code, a command strobe, a read/write direction flag, the target byte address and an array write request. The block returns a write grant that the programming sequencer uses to start (or skip) a programming cycle, and an acknowledge permit that tells the front end whether a lock command may be acknowledged. A write that is refused is still acknowledged on the bus by the front end. It simply never reaches the array. The lock flag is a register that only the block's reset clears; reset stands in for a fresh device that has never been locked.

Top module: `wp_arbiter`

## Requirements
- R1: After reset, with the pin deasserted, a write request to any address (including 0 to 127) is granted.
- R2: With the pin deasserted, a write request whose address bit 7 is 1 (addresses 128 to 255) is granted whether or not the lock flag is set.
- R3: A command strobe carrying control code 4'b0110 with the direction flag at 0 (write) arms the lock flag at the next rising clock edge. From then on, write requests with address bit 7 equal to 0 are refused.
- R4: Once armed, the lock flag stays armed under any further command (any code, either direction). Only the reset input clears it.
- R5: While the protect pin is high, no write request is granted, at any address, whether the flag is set or not.
- R6: A command strobe with code 4'b0110 and direction flag 1 (read) gets no acknowledge permit and does not arm the flag.
- R7: The acknowledge permit is high in the same cycle as a strobe carrying code 4'b0110 with direction 0. It is low when there is no strobe or when the code is anything else.
- R8: The write grant is low whenever the write request is low. For a given flag state it follows the request, pin and address in the same cycle, with no register in between.
- R9: Commands carrying the normal array code 4'b1010, in either direction, never arm the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the lock flag |
| cmd_stb | input | 1 | One-cycle strobe: a control byte has been decoded |
| cmd_code | input | 4 | Decoded 4-bit control code of that byte |
| cmd_rd | input | 1 | Direction of the command: 1 read, 0 write |
| wr_req | input | 1 | Request to program the byte at `wr_addr` |
| wr_addr | input | 8 | Target byte address of the write request |
| wp_pin | input | 1 | External protect pin, active high |
| wr_grant | output | 1 | Write may start a programming cycle |
| lock_ack_ok | output | 1 | Lock command may be acknowledged |

## Verification
The bench targets the address boundary at 127/128. A design that decoded the lower half by magnitude or tested the wrong bit would lock the upper half, or leave byte 127 open. It sends a read with the lock code, which a careless decoder would acknowledge or let arm the lock. It sends a long stream of other commands after arming, which would show a flag that can be cleared or toggled. Random stimulus that mixes the pin with both flag states would expose a pin that only overrides one half, and mid-run resets confirm that reset, and nothing else, returns the array to fully writable.

// File: rtl/wp_pkg.sv
// Package: shared constants for the write-protection arbiter.
// Assumes control codes arrive already decoded as a 4-bit field.
package wp_pkg;
    localparam int CODE_W = 4;
    localparam int ADDR_W = 8;
    localparam logic [CODE_W-1:0] CODE_LOCK  = 4'b0110;
    localparam logic [CODE_W-1:0] CODE_ARRAY = 4'b1010;

    typedef struct packed {
        logic              stb;
        logic [CODE_W-1:0] code;
        logic              rd;
    } wp_cmd_t;
endpackage

// File: rtl/wp_cmd_decode.sv
// Module: wp_cmd_decode
// Classifies a decoded control byte. It flags lock commands (lock code,
// write direction) for arming and acknowledging. Reads carrying the lock
// code are refused. Assumes strobe is a one-cycle pulse.
module wp_cmd_decode
    import wp_pkg::*;
#(
    parameter logic [CODE_W-1:0] LOCK_CODE = CODE_LOCK
) (
    input  logic    clk,
    input  logic    rst_n,
    input  wp_cmd_t cmd,
    output logic    lock_set,
    output logic    ack_ok
);
    logic code_hit;

    // Purpose: detect a well-formed lock command in the current cycle.
    always_comb begin
        code_hit = (cmd.code == LOCK_CODE);
        lock_set = cmd.stb && code_hit && !cmd.rd;
        ack_ok   = lock_set;
    end

    // R6: a read with the lock code never gets an acknowledge permit
    a_r6_read_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.stb && cmd.rd) |-> !ack_ok);

    // R7: no strobe means no permit
    a_r7_no_stb_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd.stb |-> !ack_ok);
endmodule

// File: rtl/wp_lock_flag.sv
// Module: wp_lock_flag
// Sticky one-time lock. Set by an arm pulse, cleared only by reset.
// Assumes reset models a power cycle of a never-locked device.
module wp_lock_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic locked
);
    // Purpose: hold the lock; reset is the only way back to cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b0;
        else if (arm)
            locked <= 1'b1;
    end

    // R4: once armed the flag never drops while out of reset
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R3: an arm pulse leaves the flag set on the following cycle
    a_r3_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> locked);

    // R9: without an arm pulse a cleared flag stays cleared
    a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !arm) |=> !locked);
endmodule

// File: rtl/wp_grant.sv
// Module: wp_grant
// Combinational write permission. The pin blocks everything; the lock
// blocks only addresses whose top bit is 0. Assumes wr_addr is stable
// while wr_req is high. PIN_ACTIVE_HIGH selects the pin polarity.
module wp_grant #(
    parameter int ADDR_W          = 8,
    parameter bit PIN_ACTIVE_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              pin_raw,
    input  logic              locked,
    output logic              grant
);
    localparam int TOP_BIT = ADDR_W - 1;

    logic pin_on;
    logic low_half;

    // Purpose: normalise pin polarity to active-high.
    generate
        if (PIN_ACTIVE_HIGH) begin : g_pin_hi
            assign pin_on = pin_raw;
        end else begin : g_pin_lo
            assign pin_on = !pin_raw;
        end
    endgenerate

    // Purpose: combine request, pin, lock and region into the grant.
    always_comb begin
        low_half = !wr_addr[TOP_BIT];
        grant    = wr_req && !pin_on && !(locked && low_half);
    end

    // R5: an asserted pin refuses every write
    a_r5_pin_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        pin_on |-> !grant);

    // R2: upper half open whenever the pin is off
    a_r2_upper_open: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !pin_on && wr_addr[TOP_BIT]) |-> grant);

    // R8: no request, no grant
    a_r8_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |-> !grant);
endmodule

// File: rtl/wp_arbiter.sv
// Module: wp_arbiter (top)
// Write-protection arbiter for a 256-byte array. It combines the one-time
// lower-half lock with the whole-array protect pin. Assumes commands
// arrive pre-decoded from the serial front end.
module wp_arbiter
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              cmd_rd,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wp_pin,
    output logic              wr_grant,
    output logic              lock_ack_ok
);
    wp_cmd_t cmd;
    logic    lock_set;
    logic    locked;

    // Purpose: bundle the command fields for the decoder.
    always_comb begin
        cmd.stb  = cmd_stb;
        cmd.code = cmd_code;
        cmd.rd   = cmd_rd;
    end

    wp_cmd_decode #(.LOCK_CODE(CODE_LOCK)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .lock_set (lock_set),
        .ack_ok   (lock_ack_ok)
    );

    wp_lock_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (lock_set),
        .locked (locked)
    );

    wp_grant #(.ADDR_W(ADDR_W), .PIN_ACTIVE_HIGH(1'b1)) u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .pin_raw (wp_pin),
        .locked  (locked),
        .grant   (wr_grant)
    );

    // R6 and R9: array-code or read commands never raise the lock permit
    a_r9_array_code_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_code == CODE_ARRAY) |-> !lock_ack_ok);
endmodule

// File: tb/wp_arbiter_tb.sv
// Bench: directed corners plus seeded random traffic against a model.
module wp_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_stb;
    logic [3:0] cmd_code;
    logic       cmd_rd;
    logic       wr_req;
    logic [7:0] wr_addr;
    logic       wp_pin;
    logic       wr_grant;
    logic       lock_ack_ok;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  exp_lock = 1'b0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    wp_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
        .cmd_rd(cmd_rd), .wr_req(wr_req), .wr_addr(wr_addr), .wp_pin(wp_pin),
        .wr_grant(wr_grant), .lock_ack_ok(lock_ack_ok)
    );

    function automatic bit model_grant(bit lk, bit pin, bit [7:0] a, bit req);
        return req && !pin && !(lk && a < 8'd128);
    endfunction

    function automatic bit model_ack(bit stb, bit [3:0] code, bit rd);
        return stb && code == 4'b0110 && !rd;
    endfunction

    task automatic chk(bit act, bit exp, string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check, then update the model.
    task automatic step(bit rn, bit stb, bit [3:0] code, bit rd,
                        bit req, bit [7:0] a, bit pin, string gtag, string atag);
        @(negedge clk);
        rst_n = rn; cmd_stb = stb; cmd_code = code; cmd_rd = rd;
        wr_req = req; wr_addr = a; wp_pin = pin;
        #2;
        chk(wr_grant, model_grant(exp_lock, pin, a, req), gtag);
        chk(lock_ack_ok, model_ack(stb, code, rd), atag);
        if (!rn) exp_lock = 1'b0;
        else if (model_ack(stb, code, rd)) exp_lock = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; cmd_stb = 1'b0; cmd_code = 4'h0; cmd_rd = 1'b0;
        wr_req = 1'b0; wr_addr = 8'h00; wp_pin = 1'b0;
        void'($urandom(32'd1234));
        step(0, 0, 4'h0, 0, 0, 8'h00, 0, "R8", "R7");
        step(0, 0, 4'h0, 0, 0, 8'h00, 0, "R8", "R7");
        // R1: fresh device, lower half writable
        step(1, 0, 4'h0, 0, 1, 8'h00, 0, "R1", "R7");
        step(1, 0, 4'h0, 0, 1, 8'd127, 0, "R1", "R7");
        // R6: read with lock code, no permit, no arming
        step(1, 1, 4'b0110, 1, 1, 8'd5, 0, "R6", "R6");
        step(1, 0, 4'h0, 0, 1, 8'd5, 0, "R6", "R7");
        // R9: array code in both directions does not arm
        step(1, 1, 4'b1010, 0, 0, 8'h00, 0, "R8", "R9");
        step(1, 1, 4'b1010, 1, 1, 8'd10, 0, "R9", "R9");
        step(1, 0, 4'h0, 0, 1, 8'd10, 0, "R9", "R7");
        // R5: pin blocks even with flag clear
        step(1, 0, 4'h0, 0, 1, 8'd200, 1, "R5", "R7");
        // R3, R7: arm the lock
        step(1, 1, 4'b0110, 0, 1, 8'd127, 0, "R1", "R7");
        step(1, 0, 4'h0, 0, 1, 8'd127, 0, "R3", "R7");
        step(1, 0, 4'h0, 0, 1, 8'd128, 0, "R2", "R7");
        step(1, 0, 4'h0, 0, 1, 8'd255, 1, "R5", "R7");
        // R4: every command afterwards leaves it armed
        for (int c = 0; c < 32; c++)
            step(1, 1, 4'(c), c[4], 1, 8'd0, 0, "R4", "R7");
        step(1, 0, 4'h0, 0, 1, 8'd64, 0, "R4", "R7");
        // R4: reset is the only way back
        step(0, 0, 4'h0, 0, 0, 8'd0, 0, "R8", "R7");
        step(1, 0, 4'h0, 0, 1, 8'd64, 0, "R4", "R7");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            bit rn, stb, rd, req, pin; bit [3:0] code; bit [7:0] a;
            string gt, at;
            rn   = ($urandom % 200) != 0;
            stb  = ($urandom % 4) == 0;
            code = (($urandom % 3) == 0) ? 4'b0110 :
                   (($urandom % 2) == 0) ? 4'b1010 : 4'($urandom);
            rd   = $urandom % 2;
            req  = ($urandom % 4) != 0;
            a    = 8'($urandom);
            pin  = ($urandom % 5) == 0;
            if (!req) gt = "R8";
            else if (pin) gt = "R5";
            else if (a[7]) gt = "R2";
            else gt = exp_lock ? "R3" : "R1";
            at = (stb && rd && code == 4'b0110) ? "R6" : "R7";
            step(rn, stb, code, rd, req, a, pin, gt, at);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule